// File: doc/BRIEF.md
# Programmable Wait-State External Bus Controller

This block runs the external bus cycles for a CPU-side request port. Each accepted request becomes one strobed bus cycle: chip select plus a read or write strobe, with the latched address and write data. The cycle is stretched by a wait count that depends on where the address falls. The 24-bit space is cut into 1-Mbyte blocks, and each adjacent pair of blocks forms a group with its own 2-bit wait setting. Address bits 23:21 pick one of eight groups. After each cycle, a programmable number of idle states can be inserted. These keep the bus quiet so that slow devices have time to release it.

A second bus master, such as a DMA engine, asks for the external bus with a request line. The controller hands over the bus only between cycles. It signals the handover with a grant, and it holds all CPU traffic until the request is withdrawn. Software-side configuration uses a simple write port. One select value writes the whole wait map and the other writes the idle count.

Top module: `wsbus_ctrl`

## Requirements
- R1: After reset, bus_cs_n, bus_rd_n and bus_wr_n are 1, req_done and xm_gnt are 0, the idle count is 0, and every group's wait setting is 3, so that any access holds bus_cs_n low for 4 cycles.
- R2: A cycle holds bus_cs_n low for exactly 1+W consecutive clock cycles. W is the 2-bit field at bits [2g+1:2g] of the wait map, where g = address bits 23:21. The map is written with cfg_we=1, cfg_sel=0 and cfg_wdata.
- R3: Two addresses that differ only in bit 20 (the two 1-Mbyte blocks of one group) always get the same cycle length. Addresses in different groups use their own fields.
- R4: Writing cfg_we=1 with cfg_sel=1 sets the idle count I from cfg_wdata[1:0]. When a request is waiting at the end of a cycle, bus_cs_n stays high for exactly I+1 cycles before the next cycle starts.
- R5: While bus_cs_n is low, bus_addr equals the request address. A write drives bus_wr_n low, bus_rd_n high and bus_wdata with the request data. A read drives bus_rd_n low and bus_wr_n high. rd_data carries bus_rdata in the cycle where req_done is 1.
- R6: req_done is a one-cycle pulse in the last strobe cycle of each access, and it is never 1 while bus_cs_n is high.
- R7: xm_gnt never rises during a strobed cycle. A cycle already under way when xm_req rises completes at full length, and then xm_gnt rises.
- R8: While xm_gnt is 1, no strobe and no req_done appear and a pending CPU request waits. When xm_req and req_valid are both high at a cycle boundary, the external master wins. xm_gnt falls after xm_req falls, and the waiting request then runs.
- R9: A wait map write made during a cycle does not change that cycle's length. It applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes the wait map, 1 writes the idle count |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | CPU access request, held until req_done |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | Last cycle of the access |
| rd_data | output | 16 | Read data, valid with req_done |
| xm_req | input | 1 | External master bus request |
| xm_gnt | output | 1 | Bus granted to external master |
| bus_addr | output | 24 | External address |
| bus_wdata | output | 16 | External write data |
| bus_rdata | input | 16 | External read data |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
Cycle stretching is tried with three address patterns. The first visits each of the eight groups with a distinct wait pattern, which shows that the field selection is correct. The second visits the two blocks of each group, which separates group decoding from block decoding. The third mixes reads and writes, which tests strobe polarity and data routing. Back-to-back requests at each idle count show that idle states are counted separately from wait states. The handover is tried with the external request raised in three places: mid-cycle, at an idle boundary together with a CPU request, and while the CPU is stalled. A map rewrite during a cycle shows whether the wait count is captured at the start of the cycle.

// File: rtl/wsbus_ctrl.sv
module wsbus_ctrl #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 20,
  parameter int WS_W    = 2,
  parameter int IDLE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [(1<<(ADDR_W-BLK_LSB-1))*WS_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_done,
  output logic [DATA_W-1:0] rd_data,
  input  logic              xm_req,
  output logic              xm_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  localparam int GRP_LSB = BLK_LSB + 1;
  localparam int GRP_W   = ADDR_W - GRP_LSB;
  localparam int NGRP    = 1 << GRP_W;
  localparam int MAP_W   = NGRP * WS_W;

  typedef enum logic [1:0] {ST_READY, ST_ACC, ST_REC, ST_HAND} st_t;

  st_t               st;
  logic [MAP_W-1:0]  wmap;
  logic [IDLE_W-1:0] idle_q, icnt;
  logic [WS_W-1:0]   wcnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic [WS_W-1:0]   ws_tab [NGRP];
  logic [GRP_W-1:0]  grp;

  for (genvar g = 0; g < NGRP; g++) begin : g_tab
    assign ws_tab[g] = wmap[g*WS_W +: WS_W];
  end

  assign grp = req_addr[ADDR_W-1:GRP_LSB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_READY;
      wmap    <= '1;
      idle_q  <= '0;
      icnt    <= '0;
      wcnt    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      if (cfg_we) begin
        if (cfg_sel) idle_q <= cfg_wdata[IDLE_W-1:0];
        else         wmap   <= cfg_wdata;
      end
      case (st)
        ST_READY:
          if (xm_req) st <= ST_HAND;
          else if (req_valid) begin
            st      <= ST_ACC;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            we_q    <= req_we;
            wcnt    <= ws_tab[grp];
          end
        ST_ACC:
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          else if (idle_q != '0) begin
            st   <= ST_REC;
            icnt <= idle_q - 1'b1;
          end else st <= ST_READY;
        ST_REC:
          if (icnt == '0) st <= ST_READY;
          else icnt <= icnt - 1'b1;
        ST_HAND:
          if (!xm_req) st <= ST_READY;
        default: st <= ST_READY;
      endcase
    end
  end

  wire in_acc = (st == ST_ACC);

  assign bus_cs_n  = !in_acc;
  assign bus_rd_n  = !(in_acc && !we_q);
  assign bus_wr_n  = !(in_acc && we_q);
  assign req_done  = in_acc && (wcnt == '0);
  assign rd_data   = bus_rdata;
  assign xm_gnt    = (st == ST_HAND);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
endmodule

// File: rtl/wsbus_ctrl_chk.sv
module wsbus_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xm_req,
  input logic              xm_gnt,
  input logic              req_done,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic [ADDR_W-1:0] bus_addr
);
  // R6
  done_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !bus_cs_n);

  // R2
  strobe_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !req_done) |=> (!bus_cs_n && $stable(bus_addr)));

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> (!bus_cs_n && (bus_rd_n != bus_wr_n)));

  // R7
  grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xm_gnt) |-> $past(bus_cs_n));

  // R8
  quiet_when_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xm_gnt |-> (bus_cs_n && !req_done));

  // R8
  grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xm_gnt && xm_req) |=> xm_gnt);
endmodule

bind wsbus_ctrl wsbus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xm_req(xm_req), .xm_gnt(xm_gnt),
  .req_done(req_done), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_addr(bus_addr)
);

// File: tb/sim_wsbus_ctrl.sv
`timescale 1ns/1ps
module sim_wsbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_done, xm_gnt, bus_cs_n, bus_rd_n, bus_wr_n;
  logic [15:0] rd_data, bus_wdata, bus_rdata;
  logic [23:0] bus_addr;
  logic        xm_req = 1'b0;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;
  assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

  wsbus_ctrl u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run_access(input [23:0] a, input bit w, input [15:0] d,
                            output int slen, output logic [15:0] rd);
    bit bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    slen = 0; rd = '0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (!bus_cs_n) begin
        slen++;
        if (bus_addr != a || (w ? (bus_wr_n || !bus_rd_n || bus_wdata != d)
                                : (bus_rd_n || !bus_wr_n))) bad = 1;
      end
      if (req_done) begin rd = rd_data; req_valid = 1'b0; break; end
    end
    chk(!bad, "R5 strobes/addr during cycle", bad, 0);
    @(negedge clk);
    chk(!req_done, "R6 done single pulse", req_done, 0);
  endtask

  task automatic t_reset;
    int n; logic [15:0] r;
    chk(bus_cs_n && bus_rd_n && bus_wr_n, "R1 strobes idle", {bus_cs_n,bus_rd_n,bus_wr_n}, 3'b111);
    chk(!req_done && !xm_gnt, "R1 done/gnt low", {req_done,xm_gnt}, 0);
    run_access(24'h000010, 1'b0, 16'h0, n, r);
    chk(n == 4, "R1 default wait group0", n, 4);
    run_access(24'hE00020, 1'b1, 16'h1234, n, r);
    chk(n == 4, "R1 default wait group7", n, 4);
  endtask

  task automatic t_groups;
    int n; logic [15:0] r; logic [15:0] map; int ws [8];
    ws = '{0, 1, 2, 3, 1, 0, 3, 2};
    map = '0;
    for (int g = 0; g < 8; g++) map[2*g +: 2] = ws[g][1:0];
    cfg_write(1'b0, map);
    for (int g = 0; g < 8; g++) begin
      logic [23:0] a0, a1;
      a0 = {g[2:0], 21'h00123};
      a1 = {g[2:0], 21'h100456};
      run_access(a0, 1'b0, 16'h0, n, r);
      chk(n == ws[g] + 1, "R2 group wait length", n, ws[g] + 1);
      chk(r == (a0[15:0] ^ 16'hA5C3), "R5 read data", r, a0[15:0] ^ 16'hA5C3);
      run_access(a1, 1'b1, 16'h5A00 + 16'(g), n, r);
      chk(n == ws[g] + 1, "R3 second block same group", n, ws[g] + 1);
    end
  endtask

  task automatic t_idle(input int idl);
    int gap = 0;
    cfg_write(1'b0, 16'h0000);
    cfg_write(1'b1, 16'(idl));
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 24'h000100;
    for (int k = 0; k < 20 && !req_done; k++) @(negedge clk);
    req_addr = 24'h200200;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bus_cs_n) gap++; else break;
    end
    chk(gap == idl + 1, "R4 idle gap", gap, idl + 1);
    chk(bus_addr == 24'h200200, "R4 second cycle addr", bus_addr, 24'h200200);
    req_valid = 1'b0;
    repeat (idl + 3) @(negedge clk);
  endtask

  task automatic t_grant_mid;
    int n = 0; bit early = 0;
    cfg_write(1'b1, 16'h0000);
    cfg_write(1'b0, 16'hFFFF);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 24'h400000; req_wdata = 16'hBEEF;
    @(negedge clk); n++;
    xm_req = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (xm_gnt) early = 1;
      if (req_done) break;
      @(negedge clk); if (!bus_cs_n) n++;
    end
    req_valid = 1'b0;
    chk(!early, "R7 no grant mid cycle", early, 0);
    chk(n == 4, "R7 cycle completes full length", n, 4);
    @(negedge clk); @(negedge clk);
    chk(xm_gnt, "R7 grant after boundary", xm_gnt, 1);
    xm_req = 1'b0;
    @(negedge clk);
    chk(!xm_gnt, "R8 grant released", xm_gnt, 0);
  endtask

  task automatic t_grant_stall;
    bit quiet = 1; int n = 0;
    @(negedge clk);
    xm_req = 1'b1; req_valid = 1'b1; req_we = 1'b0; req_addr = 24'h600000;
    @(negedge clk);
    chk(xm_gnt && bus_cs_n, "R8 external master wins", {xm_gnt,bus_cs_n}, 2'b11);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!bus_cs_n || req_done || !xm_gnt) quiet = 0;
    end
    chk(quiet, "R8 cpu stalled while granted", quiet, 1);
    xm_req = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!bus_cs_n) n++;
      if (req_done) break;
    end
    req_valid = 1'b0;
    chk(n == 4, "R8 pending request runs after release", n, 4);
    @(negedge clk);
  endtask

  task automatic t_midwrite;
    int n = 0, n2; logic [15:0] r;
    cfg_write(1'b0, 16'hFFFF);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 24'h000040;
    @(negedge clk); n++;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0000;
    @(negedge clk); cfg_we = 1'b0; if (!bus_cs_n) n++;
    for (int k = 0; k < 10 && !req_done; k++) begin
      @(negedge clk); if (!bus_cs_n) n++;
    end
    req_valid = 1'b0;
    chk(n == 4, "R9 running cycle keeps wait", n, 4);
    @(negedge clk);
    run_access(24'h000080, 1'b0, 16'h0, n2, r);
    chk(n2 == 1, "R9 next cycle uses new wait", n2, 1);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_groups();
    for (int i = 0; i < 4; i++) t_idle(i);
    t_grant_mid();
    t_grant_stall();
    t_midwrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule